// File: doc/BRIEF.md
# Verified Open-Drain Latch Write Engine

This block is a command handler that works at the byte level and owns a small open-drain output latch. A byte layer below it deserialises the line. That layer hands over each received byte with a one-cycle valid strobe, and it accepts bytes for transmission through a request/acknowledge pair. It also signals a bus reset, which marks the start of a new transaction.

The first byte after a bus reset is taken as a command code. When the code is the latch write code, the engine enters an endless loop. Each pass takes a new-state byte and then its bitwise complement. When the two agree, the engine commits the new state to the latch one cycle later. It then offers a fixed confirmation byte, samples the pin levels when that byte is taken, and offers the sampled status as a second byte. After that it waits for the next byte pair. A failed complement check or an unknown command makes the engine ignore the bus until the next bus reset. A bus reset is honoured in every state.

Top module: `latch_cmd_engine`

## Requirements
- R1: After `rst_n` is released, `latch_q` is FFh, `drive_on` is 0 on every channel and `tx_req` is 0.
- R2: The first byte received after a bus reset is the command. Only 5Ah starts the write loop. Any other value makes the engine ignore all received bytes until the next bus reset: the latch does not change and `tx_req` stays 0.
- R3: A byte pair updates the latch only when the second byte is the bitwise complement of the first. On a mismatch the latch keeps its value, nothing is transmitted, and later bytes are ignored until a bus reset.
- R4: Suppose the complement byte is accepted on clock edge k. Then `latch_q` still holds its old value after edge k and holds the new byte after edge k+1.
- R5: Bit 0 of the latch controls channel P0 and bit 1 controls channel P1. `drive_on[i]` is 1 (transistor conducting) exactly when latch bit i is 0.
- R6: After a commit, `tx_req` rises with `tx_byte` = AAh. Both hold until `tx_ack` is seen.
- R7: `pin_lvl` is sampled on the edge that acknowledges the AAh byte. The next byte offered is the status byte: bits 1:0 are the sampled P1/P0 levels and bits 7:2 are all 1. It is held until `tx_ack`.
- R8: After the status byte is acknowledged, `tx_req` drops. The engine accepts a further byte pair without a new command code.
- R9: A bus reset in any state makes the engine wait for a command code, and `tx_req` is 0 after that edge. A latch value that is already committed is kept.
- R10: The polarity-select input `pol_sel` has no effect on any output.
- R11: A received byte that arrives while a byte is being offered for transmission is ignored. The offered byte and the latch do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset strobe from the byte layer |
| pol_sel | input | 1 | Polarity-select pin level, unused by this command |
| rx_vld | input | 1 | One-cycle strobe: a received byte is on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| tx_req | output | 1 | A byte is offered for transmission |
| tx_byte | output | 8 | Byte offered for transmission |
| tx_ack | input | 1 | Byte layer has taken `tx_byte` |
| pin_lvl | input | NCH (2) | Present levels of the output pins |
| latch_q | output | 8 | Output latch contents |
| drive_on | output | NCH (2) | Open-drain transistor enable per channel |

## Verification
The assertions assume that the byte layer raises `tx_ack` only while `tx_req` is high and keeps `rx_vld` to single-cycle pulses. They also assume that `pin_lvl` is steady at the edge that acknowledges the confirmation byte, so that the status byte can be compared against its value one cycle earlier. The bench drives every input on the falling clock edge, pulses each strobe for exactly one cycle, and acknowledges only after it has seen the request. Received bytes arrive during an offered byte only in the one scenario that tests R11, and there they stay single-cycle pulses.

// File: rtl/lwe_pkg.sv
package lwe_pkg;

  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_CMD    = 3'd0,
    ST_NEW    = 3'd1,
    ST_INV    = 3'd2,
    ST_COMMIT = 3'd3,
    ST_CONF   = 3'd4,
    ST_STAT   = 3'd5,
    ST_HALT   = 3'd6
  } lwe_state_t;

  // True when every bit of b is the opposite of the same bit of a.
  function automatic logic pair_is_inverse(input byte_t a, input byte_t b);
    byte_t x;
    x = a ^ b;
    return &x;
  endfunction

  // An open-drain transistor conducts when its latch bit is 0.
  function automatic logic conducts(input logic latch_bit);
    return latch_bit == 1'b0;
  endfunction

endpackage

// File: rtl/lwe_cmd_fsm.sv
module lwe_cmd_fsm
  import lwe_pkg::*;
#(
  parameter byte_t CMD_CODE = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       rx_vld,
  input  byte_t      rx_byte,
  input  logic       tx_ack,
  output lwe_state_t state_o,
  output byte_t      new_byte,
  output logic       cmd_hit_evt,
  output logic       pair_ok_evt,
  output logic       pair_bad_evt,
  output logic       commit_evt,
  output logic       conf_done,
  output logic       stat_done
);

  lwe_state_t state_q, state_d;
  byte_t      new_q;
  logic       pair_ok;

  assign pair_ok = pair_is_inverse(new_q, rx_byte);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CMD:    if (rx_vld) state_d = (rx_byte == CMD_CODE) ? ST_NEW : ST_HALT;
      ST_NEW:    if (rx_vld) state_d = ST_INV;
      ST_INV:    if (rx_vld) state_d = pair_ok ? ST_COMMIT : ST_HALT;
      ST_COMMIT: state_d = ST_CONF;
      ST_CONF:   if (tx_ack) state_d = ST_STAT;
      ST_STAT:   if (tx_ack) state_d = ST_NEW;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_HALT;
    endcase
    if (bus_rst) state_d = ST_CMD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_q <= '1;
    end else if (state_q == ST_NEW && rx_vld && !bus_rst) begin
      new_q <= rx_byte;
    end
  end

  // Named events for the checker and the datapath.
  assign cmd_hit_evt  = (state_q == ST_CMD) && rx_vld && !bus_rst && (rx_byte == CMD_CODE);
  assign pair_ok_evt  = (state_q == ST_INV) && rx_vld && !bus_rst && pair_ok;
  assign pair_bad_evt = (state_q == ST_INV) && rx_vld && !bus_rst && !pair_ok;
  assign commit_evt   = (state_q == ST_COMMIT) && !bus_rst;
  assign conf_done    = (state_q == ST_CONF) && tx_ack && !bus_rst;
  assign stat_done    = (state_q == ST_STAT) && tx_ack && !bus_rst;

  assign state_o  = state_q;
  assign new_byte = new_q;

endmodule

// File: rtl/lwe_latch_bank.sv
module lwe_latch_bank
  import lwe_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  byte_t          new_byte,
  output byte_t          latch_q,
  output logic [NCH-1:0] drive_on
);

  byte_t lat_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_r <= '1;
    end else if (commit) begin
      lat_r <= new_byte;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign drive_on[i] = conducts(lat_r[i]);
  end

  assign latch_q = lat_r;

endmodule

// File: rtl/lwe_tx_path.sv
module lwe_tx_path
  import lwe_pkg::*;
#(
  parameter int    NCH      = 2,
  parameter byte_t CONF_PAT = 8'hAA
) (
  input  logic           clk,
  input  logic           rst_n,
  input  lwe_state_t     state,
  input  logic           conf_done,
  input  logic [NCH-1:0] pin_lvl,
  output logic           tx_req,
  output byte_t          tx_byte
);

  byte_t pad_pins;
  byte_t stat_q;

  // Pins without a channel read back as 1.
  for (genvar i = 0; i < BYTE_W; i++) begin : g_pad
    if (i < NCH) begin : g_pin
      assign pad_pins[i] = pin_lvl[i];
    end else begin : g_one
      assign pad_pins[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '1;
    end else if (conf_done) begin
      stat_q <= pad_pins;
    end
  end

  assign tx_req  = (state == ST_CONF) || (state == ST_STAT);
  assign tx_byte = (state == ST_CONF) ? CONF_PAT : stat_q;

endmodule

// File: rtl/latch_cmd_engine.sv
module latch_cmd_engine
  import lwe_pkg::*;
#(
  parameter int    NCH      = 2,
  parameter byte_t CMD_CODE = 8'h5A,
  parameter byte_t CONF_PAT = 8'hAA
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_rst,
  input  logic           pol_sel,
  input  logic           rx_vld,
  input  logic [7:0]     rx_byte,
  output logic           tx_req,
  output logic [7:0]     tx_byte,
  input  logic           tx_ack,
  input  logic [NCH-1:0] pin_lvl,
  output logic [7:0]     latch_q,
  output logic [NCH-1:0] drive_on
);

  lwe_state_t state;
  byte_t      new_byte;
  logic       cmd_hit_evt;
  logic       pair_ok_evt;
  logic       pair_bad_evt;
  logic       commit_evt;
  logic       conf_done;
  logic       stat_done;

  lwe_cmd_fsm #(.CMD_CODE(CMD_CODE)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rst      (bus_rst),
    .rx_vld       (rx_vld),
    .rx_byte      (rx_byte),
    .tx_ack       (tx_ack),
    .state_o      (state),
    .new_byte     (new_byte),
    .cmd_hit_evt  (cmd_hit_evt),
    .pair_ok_evt  (pair_ok_evt),
    .pair_bad_evt (pair_bad_evt),
    .commit_evt   (commit_evt),
    .conf_done    (conf_done),
    .stat_done    (stat_done)
  );

  lwe_latch_bank #(.NCH(NCH)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit_evt),
    .new_byte (new_byte),
    .latch_q  (latch_q),
    .drive_on (drive_on)
  );

  lwe_tx_path #(.NCH(NCH), .CONF_PAT(CONF_PAT)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .conf_done (conf_done),
    .pin_lvl   (pin_lvl),
    .tx_req    (tx_req),
    .tx_byte   (tx_byte)
  );

endmodule

// File: rtl/lwe_checker.sv
module lwe_checker #(
  parameter int         NCH      = 2,
  parameter logic [7:0] CONF_PAT = 8'hAA
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_rst,
  input logic           pol_sel,
  input logic           tx_req,
  input logic           tx_ack,
  input logic [7:0]     tx_byte,
  input logic [NCH-1:0] pin_lvl,
  input logic [7:0]     latch_q,
  input logic [7:0]     new_byte,
  input logic           pair_ok_evt,
  input logic           pair_bad_evt,
  input logic           commit_evt
);

  // R3: the latch moves only on a commit.
  a_r3_latch_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_q) |-> $past(commit_evt));

  // R3: a commit follows a validated complement pair.
  a_r3_commit_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> $past(pair_ok_evt));

  // R3: a failed pair never leads to a transmission.
  a_r3_bad_pair_silent: assert property (@(posedge clk) disable iff (!rst_n)
    pair_bad_evt |=> !tx_req);

  // R4: the committed value is the stored new-state byte.
  a_r4_commit_value: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> latch_q == $past(new_byte));

  // R6: every new transmission starts with the confirmation pattern.
  a_r6_conf_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req) |-> (tx_byte == CONF_PAT) && $past(commit_evt));

  // R6, R7: an offered byte is held until taken.
  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_ack && !bus_rst |=> tx_req && $stable(tx_byte));

  // R7: status follows the confirmation and carries the sampled pins.
  a_r7_status_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_ack && !bus_rst && (tx_byte == CONF_PAT) |=>
      tx_req && (tx_byte[NCH-1:0] == $past(pin_lvl)) && (&tx_byte[7:NCH]));

  // R9: a bus reset withdraws any offered byte.
  a_r9_bus_reset_drops_tx: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !tx_req);

  // R10: a polarity change alone leaves the latch alone.
  a_r10_pol_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_sel != $past(pol_sel)) && !commit_evt |=> $stable(latch_q));

endmodule

bind latch_cmd_engine lwe_checker #(.NCH(NCH), .CONF_PAT(CONF_PAT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_rst      (bus_rst),
  .pol_sel      (pol_sel),
  .tx_req       (tx_req),
  .tx_ack       (tx_ack),
  .tx_byte      (tx_byte),
  .pin_lvl      (pin_lvl),
  .latch_q      (latch_q),
  .new_byte     (new_byte),
  .pair_ok_evt  (pair_ok_evt),
  .pair_bad_evt (pair_bad_evt),
  .commit_evt   (commit_evt)
);

// File: tb/tb_latch_cmd_engine.sv
`timescale 1ns/1ps
module tb_latch_cmd_engine;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst = 1'b0;
  logic       pol_sel = 1'b0;
  logic       rx_vld = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tx_req;
  logic [7:0] tx_byte;
  logic       tx_ack = 1'b0;
  logic [1:0] pin_lvl = 2'b11;
  logic [7:0] latch_q;
  logic [1:0] drive_on;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] ref_lat = 8'hFF;

  always #2 clk = ~clk;

  latch_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .pol_sel(pol_sel),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .tx_req(tx_req), .tx_byte(tx_byte),
    .tx_ack(tx_ack), .pin_lvl(pin_lvl), .latch_q(latch_q), .drive_on(drive_on)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every driver task starts and ends on a falling edge.
  task automatic send_byte(input logic [7:0] b);
    rx_vld = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_vld = 1'b0;
  endtask

  task automatic bus_pulse();
    bus_rst = 1'b1;
    @(negedge clk);
    bus_rst = 1'b0;
  endtask

  task automatic ack_one();
    tx_ack = 1'b1;
    @(negedge clk);
    tx_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 latch", latch_q, 8'hFF);
    chk("R1 drive", {6'd0, drive_on}, 8'h00);
    chk("R1 tx_req", {7'd0, tx_req}, 8'h00);
  endtask

  task automatic t_good_pair(input logic [7:0] nv, input logic [1:0] pins, input bit noise);
    pin_lvl = pins;
    send_byte(nv);
    send_byte(~nv);
    chk("R4 latch old after accept", latch_q, ref_lat);
    chk("R4 no tx yet", {7'd0, tx_req}, 8'h00);
    @(negedge clk);
    chk("R4 latch new", latch_q, nv);
    chk("R5 drive", {6'd0, drive_on}, {6'd0, ~nv[1:0]});
    chk("R6 tx_req", {7'd0, tx_req}, 8'h01);
    chk("R6 conf byte", tx_byte, 8'hAA);
    if (noise) begin
      send_byte(8'h00);
      chk("R11 conf kept", tx_byte, 8'hAA);
      chk("R11 latch kept", latch_q, nv);
    end
    ack_one();
    pin_lvl = ~pins;
    chk("R7 status req", {7'd0, tx_req}, 8'h01);
    chk("R7 status byte", tx_byte, {6'h3F, pins});
    ack_one();
    chk("R8 idle after status", {7'd0, tx_req}, 8'h00);
    ref_lat = nv;
  endtask

  task automatic t_bad_pair();
    send_byte(8'h00);
    send_byte(8'h0F);
    @(negedge clk);
    chk("R3 no tx on mismatch", {7'd0, tx_req}, 8'h00);
    chk("R3 latch kept", latch_q, ref_lat);
    send_byte(8'h00);
    send_byte(8'hFF);
    repeat (2) @(negedge clk);
    chk("R3 silent after mismatch", latch_q, ref_lat);
    chk("R3 no tx later", {7'd0, tx_req}, 8'h00);
  endtask

  task automatic t_wrong_cmd();
    bus_pulse();
    send_byte(8'h3C);
    send_byte(8'h5A);
    send_byte(8'hFF);
    send_byte(8'h00);
    repeat (2) @(negedge clk);
    chk("R2 latch kept", latch_q, ref_lat);
    chk("R2 no tx", {7'd0, tx_req}, 8'h00);
  endtask

  task automatic t_bus_abort();
    bus_pulse();
    send_byte(8'h5A);
    send_byte(8'hFC);
    bus_pulse();
    send_byte(8'h03);
    repeat (2) @(negedge clk);
    chk("R9 pair aborted", latch_q, ref_lat);
    bus_pulse();
    send_byte(8'h5A);
    send_byte(8'hFC);
    send_byte(8'h03);
    @(negedge clk);
    chk("R9 conf offered", {7'd0, tx_req}, 8'h01);
    bus_pulse();
    chk("R9 tx dropped", {7'd0, tx_req}, 8'h00);
    chk("R9 committed kept", latch_q, 8'hFC);
    ref_lat = 8'hFC;
    send_byte(8'h5A);
    t_good_pair(8'hFF, 2'b11, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    bus_pulse();
    send_byte(8'h5A);
    t_good_pair(8'hFE, 2'b10, 1'b0);
    pol_sel = 1'b1;
    t_good_pair(8'hFD, 2'b01, 1'b1);
    chk("R10 latch with pol high", latch_q, 8'hFD);
    pol_sel = 1'b0;
    t_good_pair(8'h5A, 2'b11, 1'b0);
    t_bad_pair();
    bus_pulse();
    send_byte(8'h5A);
    t_good_pair(8'h00, 2'b00, 1'b0);
    t_wrong_cmd();
    t_bus_abort();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule